// File: doc/BRIEF.md
# Device Power State Controller

This block keeps track of the power management state of a network controller. The controller can be in one of four states: bus reset, powered but not yet set up, fully running, and deep sleep. The inputs are a power-good level, an active-low bus reset, the memory-access-enable configuration bit and a requested sleep level from the host. From these the block drives:

- two power-state indicator pins,
- the enable for its bus output drivers,
- a transmit enable,
- a PHY reset pulse,
- a configuration-memory reload request,
- the wake-up enable flag.

The configuration memory and the PHY are outside the block. The memory is reached only through a request/done handshake, and the done strobe carries the advanced power management flag read from it.

While the bus reset is held low, the block sits in the reset state and its bus outputs are off. Any wake-up setting made before the reset is kept. The bus outputs stay off for a fixed hold interval after the block leaves reset, which models a limit of about one millisecond. The block enters the powered-but-unconfigured state in two cases: when the bus reset is released, or when the host asks to leave deep sleep. Each time it enters that state, it clears wake-up, resets the PHY and reloads the configuration memory. It waits there until the host enables memory access.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While the chip reset `rst_n` is low, `state` is 0, and `wake_en`, `cfg_req`, `phy_rst`, `bus_oe` and `tx_en` are all 0.
- R2: The first time `pwr_good` is seen high after chip reset, `cfg_req` goes high on the next cycle. `cfg_req` stays high until a cycle with `cfg_done` high. In that cycle `wake_en` takes the value of `cfg_apm`. A `cfg_done` pulse that arrives while no request is open changes nothing.
- R3: A cycle with `bus_rst_n` low makes `state` 0 on the next cycle, whatever the current state.
- R4: While `state` is 0, `bus_oe` and `tx_en` are low. After `state` leaves 0, `bus_oe` stays low for exactly `HOLD_CYC` more cycles.
- R5: While the block stays in state 0, `wake_en` keeps its value, unless an open configuration read completes.
- R6: Outside state 2, `pwr_ind1` is low and `pwr_ind0` equals `wake_en`.
- R7: From state 0 the block moves to state 1 on the cycle after `bus_rst_n` and `pwr_good` are both high. Otherwise it stays in state 0.
- R8: On every entry into state 1:
  - `wake_en` is 0,
  - `phy_rst` is high for exactly `PHY_PULSE` cycles starting at the entry cycle,
  - `cfg_req` is raised.
- R9: From state 1 the block moves to state 2 on the cycle after `mem_en` is high.
- R10: In state 2, `tx_en`, `pwr_ind0` and `pwr_ind1` are high.
- R11: Transitions on `req_state`:
  - In state 2, `req_state` = 3 moves the block to state 3 on the next cycle.
  - In state 3, `req_state` = 0 moves it to state 1.
  - All other values leave these states unchanged.
- R12: `state` encodes reset = 0, unconfigured = 1, running = 2, sleep = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low, asserted asynchronously |
| pwr_good | input | 1 | Auxiliary power is stable |
| bus_rst_n | input | 1 | Host bus reset, active low, synchronous to clk |
| mem_en | input | 1 | Memory-access-enable configuration bit |
| req_state | input | 2 | Sleep level requested by the host (0 = on, 3 = deep sleep) |
| cfg_done | input | 1 | Configuration read finished |
| cfg_apm | input | 1 | Advanced power management flag returned with cfg_done |
| state | output | 2 | Current power state |
| pwr_ind0 | output | 1 | Power-state indicator 0 |
| pwr_ind1 | output | 1 | Power-state indicator 1 |
| bus_oe | output | 1 | Bus output drivers enabled |
| tx_en | output | 1 | Transmit enable |
| phy_rst | output | 1 | PHY reset pulse |
| cfg_req | output | 1 | Configuration reload request |
| wake_en | output | 1 | Wake-up enabled |

## Verification
The bench targets the following corner cases, each with the failure a wrong design would show:

- **Hold interval after reset.** A design that counts the hold wrongly enables its bus drivers one cycle early or one cycle late after leaving reset.
- **Wake setting across reset.** A design that clears wake-up on entering reset drops indicator 0 during a bus reset that follows a wake-enabled read.
- **Stray done strobe.** A design that accepts a `cfg_done` with no open request would overwrite the wake flag.
- **Leaving deep sleep.** A design that takes unsupported `req_state` values as commands would leave running or sleep early. A design that returns from sleep straight to running would skip the PHY reset and the reload.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  typedef enum logic [1:0] {
    PS_RESET  = 2'd0,
    PS_UNINIT = 2'd1,
    PS_ACTIVE = 2'd2,
    PS_SLEEP  = 2'd3
  } pstate_t;

  localparam logic [1:0] REQ_ON    = 2'd0;
  localparam logic [1:0] REQ_SLEEP = 2'd3;
endpackage

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_state_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst_n,
  input  logic       pwr_good,
  input  logic       mem_en,
  input  logic [1:0] req_state,
  output pstate_t    st,
  output logic       enter_uninit
);
  pstate_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!bus_rst_n) begin
      st_d = PS_RESET;
    end else begin
      case (st_q)
        PS_RESET:  if (pwr_good)               st_d = PS_UNINIT;
        PS_UNINIT: if (mem_en)                 st_d = PS_ACTIVE;
        PS_ACTIVE: if (req_state == REQ_SLEEP) st_d = PS_SLEEP;
        PS_SLEEP:  if (req_state == REQ_ON)    st_d = PS_UNINIT;
        default:                               st_d = PS_RESET;
      endcase
    end
  end

  assign enter_uninit = (st_d == PS_UNINIT) && (st_q != PS_UNINIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_RESET;
    else        st_q <= st_d;
  end

  assign st = st_q;
endmodule

// File: rtl/pwr_dcount.sv
module pwr_dcount #(
  parameter int CNT_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int W = $clog2(CNT_MAX + 1);
  localparam logic [W-1:0] RELOAD = W'(CNT_MAX);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = load || busy;

  always_comb begin
    if (load) cnt_d = RELOAD;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic enter_uninit,
  input  logic cfg_done,
  input  logic cfg_apm,
  output logic cfg_req,
  output logic wake_en
);
  logic pend_q, pend_d;
  logic wake_q, wake_d;
  logic seen_q;
  logic first_pg;

  assign first_pg = pwr_good && !seen_q;

  always_comb begin
    pend_d = pend_q;
    wake_d = wake_q;
    if (enter_uninit) begin
      wake_d = 1'b0;
      pend_d = 1'b1;
    end else begin
      if (pend_q && cfg_done) begin
        wake_d = cfg_apm;
        pend_d = 1'b0;
      end
      if (first_pg) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wake_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      wake_q <= wake_d;
      if (first_pg) seen_q <= 1'b1;
    end
  end

  assign cfg_req = pend_q;
  assign wake_en = wake_q;
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int HOLD_CYC  = 200000,
  parameter int PHY_PULSE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       bus_rst_n,
  input  logic       mem_en,
  input  logic [1:0] req_state,
  input  logic       cfg_done,
  input  logic       cfg_apm,
  output logic [1:0] state,
  output logic       pwr_ind0,
  output logic       pwr_ind1,
  output logic       bus_oe,
  output logic       tx_en,
  output logic       phy_rst,
  output logic       cfg_req,
  output logic       wake_en
);
  pstate_t st;
  logic    enter_uninit;
  logic    hold_busy;
  logic    in_reset;
  logic    running;

  pwr_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rst_n    (bus_rst_n),
    .pwr_good     (pwr_good),
    .mem_en       (mem_en),
    .req_state    (req_state),
    .st           (st),
    .enter_uninit (enter_uninit)
  );

  assign in_reset = (st == PS_RESET);
  assign running  = (st == PS_ACTIVE);

  pwr_dcount #(.CNT_MAX(HOLD_CYC)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_reset),
    .busy  (hold_busy)
  );

  pwr_dcount #(.CNT_MAX(PHY_PULSE)) u_phy (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (enter_uninit),
    .busy  (phy_rst)
  );

  pwr_wake_ctl u_wake (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .enter_uninit (enter_uninit),
    .cfg_done     (cfg_done),
    .cfg_apm      (cfg_apm),
    .cfg_req      (cfg_req),
    .wake_en      (wake_en)
  );

  assign state    = st;
  assign bus_oe   = !in_reset && !hold_busy;
  assign tx_en    = running;
  assign pwr_ind1 = running;
  assign pwr_ind0 = running || wake_en;
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rst_n,
  input logic       mem_en,
  input logic [1:0] req_state,
  input logic       cfg_done,
  input logic [1:0] state,
  input logic       pwr_ind0,
  input logic       pwr_ind1,
  input logic       bus_oe,
  input logic       tx_en,
  input logic       phy_rst,
  input logic       cfg_req,
  input logic       wake_en
);
  a_r3_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_n |=> state == 2'd0);

  a_r4_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd0 |-> !bus_oe && !tx_en);

  a_r5_keep_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && $past(state) == 2'd0 && !$past(cfg_done))
      |-> wake_en == $past(wake_en));

  a_r6_indicators: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd2 |-> !pwr_ind1 && (pwr_ind0 == wake_en));

  a_r8_uninit_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && $past(state) != 2'd1) |-> !wake_en && phy_rst && cfg_req);

  a_r9_mem_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && mem_en && bus_rst_n) |=> state == 2'd2);

  a_r10_running: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd2 |-> tx_en && pwr_ind0 && pwr_ind1);

  a_r11_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && req_state == 2'd3 && bus_rst_n) |=> state == 2'd3);
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rst_n (bus_rst_n),
  .mem_en    (mem_en),
  .req_state (req_state),
  .cfg_done  (cfg_done),
  .state     (state),
  .pwr_ind0  (pwr_ind0),
  .pwr_ind1  (pwr_ind1),
  .bus_oe    (bus_oe),
  .tx_en     (tx_en),
  .phy_rst   (phy_rst),
  .cfg_req   (cfg_req),
  .wake_en   (wake_en)
);

// File: tb/pwr_state_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb;
  localparam int HOLD  = 12;
  localparam int PULSE = 3;
  localparam int LIMIT = 5000;

  logic       clk = 1'b0;
  logic       rst_n, pwr_good, bus_rst_n, mem_en, cfg_done, cfg_apm;
  logic [1:0] req_state;
  logic [1:0] state;
  logic       pwr_ind0, pwr_ind1, bus_oe, tx_en, phy_rst, cfg_req, wake_en;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // reference model state
  int m_st, m_hold, m_phy;
  bit m_wake, m_pend, m_seen;

  always #2.5 clk = ~clk;

  pwr_state_ctrl #(.HOLD_CYC(HOLD), .PHY_PULSE(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .bus_rst_n(bus_rst_n),
    .mem_en(mem_en), .req_state(req_state), .cfg_done(cfg_done), .cfg_apm(cfg_apm),
    .state(state), .pwr_ind0(pwr_ind0), .pwr_ind1(pwr_ind1), .bus_oe(bus_oe),
    .tx_en(tx_en), .phy_rst(phy_rst), .cfg_req(cfg_req), .wake_en(wake_en)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_hold = 0; m_phy = 0;
      m_wake = 0; m_pend = 0; m_seen = 0;
    end else begin
      int nst;
      bit enter, boot;
      nst = m_st;
      if (!bus_rst_n) nst = 0;
      else if (m_st == 0 && pwr_good) nst = 1;
      else if (m_st == 1 && mem_en) nst = 2;
      else if (m_st == 2 && req_state == 2'd3) nst = 3;
      else if (m_st == 3 && req_state == 2'd0) nst = 1;
      enter = (nst == 1) && (m_st != 1);
      boot  = pwr_good && !m_seen;
      if (m_st == 0) m_hold = HOLD;
      else if (m_hold > 0) m_hold--;
      if (enter) m_phy = PULSE;
      else if (m_phy > 0) m_phy--;
      if (enter) begin
        m_wake = 0; m_pend = 1;
      end else begin
        if (m_pend && cfg_done) begin m_wake = cfg_apm; m_pend = 0; end
        if (boot) m_pend = 1;
      end
      if (pwr_good) m_seen = 1;
      m_st = nst;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    chk("R12 state",   state,    m_st);
    chk("R4 bus_oe",   bus_oe,   (m_st != 0 && m_hold == 0));
    chk("R10 tx_en",   tx_en,    (m_st == 2));
    chk("R6 pwr_ind1", pwr_ind1, (m_st == 2));
    chk("R6 pwr_ind0", pwr_ind0, (m_st == 2) || m_wake);
    chk("R8 phy_rst",  phy_rst,  (m_phy != 0));
    chk("R2 cfg_req",  cfg_req,  m_pend);
    chk("R5 wake_en",  wake_en,  m_wake);
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, LIMIT);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; pwr_good = 0; bus_rst_n = 0; mem_en = 0;
    req_state = 2'd0; cfg_done = 0; cfg_apm = 0;
    step(3);
    // R1 reset values
    chk("R1 state", state, 0);
    chk("R1 wake_en", wake_en, 0);
    chk("R1 cfg_req", cfg_req, 0);
    chk("R1 bus_oe", bus_oe, 0);
    chk("R1 phy_rst", phy_rst, 0);
    rst_n = 1;
    step(2);
    // R2 first power-good rise starts a read
    pwr_good = 1;
    step(1);
    chk("R2 request after power-good", cfg_req, 1);
    step(2);
    cfg_done = 1; cfg_apm = 1;
    step(1);
    cfg_done = 0;
    chk("R2 wake from flag", wake_en, 1);
    chk("R6 ind0 follows wake in reset", pwr_ind0, 1);
    // stray done ignored
    cfg_done = 1; cfg_apm = 0;
    step(1);
    cfg_done = 0;
    chk("R2 stray done ignored", wake_en, 1);
    // R7 release bus reset
    bus_rst_n = 1;
    step(1);
    chk("R7 reset to uninit", state, 1);
    chk("R8 wake cleared on entry", wake_en, 0);
    chk("R8 phy pulse on entry", phy_rst, 1);
    step(4);
    cfg_done = 1; cfg_apm = 1;
    step(1);
    cfg_done = 0;
    step(12);
    mem_en = 1;
    step(1);
    chk("R9 uninit to active", state, 2);
    mem_en = 0;
    step(3);
    // R11 request handling
    req_state = 2'd1;
    step(3);
    chk("R11 level 1 ignored in active", state, 2);
    req_state = 2'd3;
    step(1);
    chk("R11 enter sleep", state, 3);
    req_state = 2'd2;
    step(3);
    chk("R11 level 2 ignored in sleep", state, 3);
    req_state = 2'd0;
    step(1);
    chk("R11 sleep exit to uninit", state, 1);
    step(2);
    cfg_done = 1; cfg_apm = 1;
    step(1);
    cfg_done = 0;
    mem_en = 1;
    step(2);
    // R3 bus reset from active, wake kept
    bus_rst_n = 0;
    step(1);
    chk("R3 active to reset", state, 0);
    step(5);
    chk("R5 wake kept in reset", wake_en, 1);
    chk("R4 outputs off in reset", bus_oe, 0);
    // power not good: stay in reset
    pwr_good = 0; bus_rst_n = 1;
    step(3);
    chk("R7 stay in reset without power-good", state, 0);
    pwr_good = 1;
    step(3);
    req_state = 2'd3;
    step(2);
    chk("R11 sleep from active again", state, 3);
    bus_rst_n = 0;
    step(1);
    chk("R3 sleep to reset", state, 0);
    step(2);
    finish_run();
  end
endmodule